// File: doc/BRIEF.md
# Multiprocessor-Filtered UART Receiver

This block is the receive half of an asynchronous serial port. It watches a serial line at sixteen times the bit rate, using an external tick pulse as its oversampling clock. It checks each start bit at mid-bit, then shifts in data bits least-significant first. It then takes an optional extra bit, which is either a parity bit or an address/data marker, and the stop bit. Completed frames move into a holding register, and status flags and interrupt requests report the result to the surrounding logic.

In multiprocessor mode every frame carries a marker bit after the data: 1 means an address frame and 0 means a data frame. A receiving node can arm a self-clearing filter bit. While the filter is armed, data frames are discarded without any effect on the register or the flags. The first address frame disarms the filter and is accepted like a normal frame, so the node wakes only for traffic addressed to the bus as a whole. The frame format is captured while reception is disabled and stays frozen while it is enabled.

Top module: `mp_uart_rx`

## Requirements
- R1: On a tick with the armed line low, a start is assumed. It is confirmed only if the line is still low at the eighth tick, otherwise the receiver returns to idle. After a frame, the line must be seen high before a new start is accepted.
- R2: Data bits are sampled every sixteen ticks after the confirmed start and are assembled least-significant bit first. When no frame is pending, a good frame is copied to `rdata` and `full` is set.
- R3: With parity enabled and multiprocessor mode off, one parity bit follows the data. Its expected value is the XOR of the data bits, inverted when odd parity is selected. A mismatch sets `per`. In multiprocessor mode no parity bit exists and `per` is never set.
- R4: A stop bit sampled low sets `fer`. The data is still transferred and `full` is set.
- R5: If a frame is accepted while `full` is 1, `ovr` is set and `rdata` keeps its old value.
- R6: While `rx_en` is 0, no frame is received. Dropping `rx_en` leaves `full`, `fer`, `per` and `ovr` unchanged.
- R7: The format inputs (`cfg_mp`, `cfg_par_en`, `cfg_par_odd`) are captured only while `rx_en` is 0. Changes while enabled have no effect until the next enable.
- R8: With `filt_en` 1 and multiprocessor mode on, a frame whose marker bit is 0 is discarded. `rdata`, `full`, `fer`, `ovr` and `mpb` stay unchanged.
- R9: With `filt_en` 1 and multiprocessor mode on, a frame whose marker bit is 1 sets `mpb` to 1, clears `filt_en` and is accepted normally.
- R10: With multiprocessor mode off, `filt_en` has no effect: frames are accepted and `filt_en` keeps its value.
- R11: `clr_flags` clears flags when its bits are 1: bit 0 clears `full`, bit 1 `fer`, bit 2 `per`, bit 3 `ovr`. A hardware set in the same cycle wins over the clear.
- R12: `rx_irq` equals `rie & full`. `err_irq` equals `rie & (fer | per | ovr)`.
- R13: In multiprocessor mode, every accepted frame copies its marker bit to `mpb`. Outside it, `mpb` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling pulse, 16 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receive enable |
| cfg_mp | input | 1 | Multiprocessor frame mode |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| filt_wr | input | 1 | Write strobe for the filter bit |
| filt_wdata | input | 1 | Value written to the filter bit |
| rie | input | 1 | Receive/error interrupt enable |
| clr_flags | input | 4 | Flag clear strobes {ovr, per, fer, full} |
| rdata | output | 8 | Received data register |
| full | output | 1 | Data register holds unread data |
| fer | output | 1 | Framing error |
| per | output | 1 | Parity error |
| ovr | output | 1 | Overrun |
| mpb | output | 1 | Last accepted marker bit |
| filt_en | output | 1 | Filter bit (self-clearing) |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The assertions cover several rules on every cycle. An armed filter never lets a frame change `full`, `fer` or `ovr`. A disabled receiver never raises a flag. An overrun never changes `rdata`. A hardware set of `full` beats a simultaneous clear. The filter only drops by itself together with `mpb` going to 1. The exact bit ordering, the parity sense, the rejection of a short start glitch and the frozen format need real serial frames, so only the bench scenarios show them.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int MPR_DATA_W = 8;
    localparam int MPR_OSR    = 16;

    localparam int CLR_FULL = 0;
    localparam int CLR_FER  = 1;
    localparam int CLR_PER  = 2;
    localparam int CLR_OVR  = 3;

    typedef struct packed {
        logic mp_mode;
        logic par_en;
        logic par_odd;
    } rx_fmt_t;

    typedef struct packed {
        logic xbit;
        logic stop_ok;
        logic par_err;
    } frm_info_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2
    } rx_st_e;

    function automatic logic has_extra(rx_fmt_t f);
        return f.mp_mode | f.par_en;
    endfunction

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
    import mpr_pkg::*;
#(
    parameter int DATA_W = MPR_DATA_W,
    parameter int OSR    = MPR_OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd_s,
    input  rx_fmt_t           fmt,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output frm_info_t         info
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_W);

    rx_st_e            st;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              xbit;
    logic              armed;
    logic [IDX_W-1:0]  idx_last;
    logic              bit_strobe;

    assign idx_last   = has_extra(fmt) ? IDX_DATA + IDX_W'(1) : IDX_DATA;
    assign bit_strobe = (st == ST_BITS) && tick && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            armed <= 1'b0;
            shreg <= '0;
            xbit  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (rxd_s) armed <= 1'b1;
                    if (tick && armed && !rxd_s) begin
                        st  <= ST_START;
                        cnt <= CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt == CNT_MID) begin
                            cnt <= '0;
                            idx <= '0;
                            st  <= rxd_s ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_BITS: begin
                    if (bit_strobe) begin
                        cnt <= '0;
                        idx <= idx + IDX_W'(1);
                        if (idx < IDX_DATA)
                            shreg <= {rxd_s, shreg[DATA_W-1:1]};
                        else if (idx == IDX_DATA && has_extra(fmt))
                            xbit <= rxd_s;
                        if (idx == idx_last) begin
                            st    <= ST_IDLE;
                            armed <= rxd_s;
                        end
                    end else if (tick) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done         = en && bit_strobe && (idx == idx_last);
    assign data         = shreg;
    assign info.xbit    = xbit;
    assign info.stop_ok = rxd_s;
    assign info.par_err = fmt.par_en && !fmt.mp_mode &&
                          (xbit != ((^shreg) ^ fmt.par_odd));
endmodule

// File: rtl/mpr_status.sv
module mpr_status
    import mpr_pkg::*;
#(
    parameter int DATA_W = MPR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  frm_info_t         info,
    input  rx_fmt_t           fmt,
    input  logic              filt_wr,
    input  logic              filt_wdata,
    input  logic [3:0]        clr,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              fer,
    output logic              per,
    output logic              ovr,
    output logic              mpb,
    output logic              filt_en,
    output logic              accept
);
    logic filt_active, drop, wake, load, fer_set, per_set, ovr_set;

    assign filt_active = filt_en && fmt.mp_mode;
    assign drop        = done && filt_active && !info.xbit;
    assign wake        = done && filt_active && info.xbit;
    assign accept      = done && !drop;
    assign load        = accept && !full;
    assign fer_set     = load && !info.stop_ok;
    assign per_set     = load && info.par_err;
    assign ovr_set     = accept && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            full    <= 1'b0;
            fer     <= 1'b0;
            per     <= 1'b0;
            ovr     <= 1'b0;
            mpb     <= 1'b0;
            filt_en <= 1'b0;
        end else begin
            if (load) rdata <= data;
            full <= load    | (full & ~clr[CLR_FULL]);
            fer  <= fer_set | (fer  & ~clr[CLR_FER]);
            per  <= per_set | (per  & ~clr[CLR_PER]);
            ovr  <= ovr_set | (ovr  & ~clr[CLR_OVR]);
            if (accept && fmt.mp_mode) mpb <= info.xbit;
            if (wake)         filt_en <= 1'b0;
            else if (filt_wr) filt_en <= filt_wdata;
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mpr_pkg::*;
#(
    parameter int DATA_W    = MPR_DATA_W,
    parameter int OSR       = MPR_OSR,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              cfg_mp,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              filt_wr,
    input  logic              filt_wdata,
    input  logic              rie,
    input  logic [3:0]        clr_flags,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              fer,
    output logic              per,
    output logic              ovr,
    output logic              mpb,
    output logic              filt_en,
    output logic              rx_irq,
    output logic              err_irq
);
    logic              rxd_s;
    rx_fmt_t           fmt_q;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    frm_info_t         frm_info;
    logic              accept;

    always_ff @(posedge clk) begin
        if (rst)         fmt_q <= '0;
        else if (!rx_en) fmt_q <= '{mp_mode: cfg_mp, par_en: cfg_par_en, par_odd: cfg_par_odd};
    end

    mpr_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(rxd_s)
    );

    mpr_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk  (clk),
        .rst  (rst),
        .en   (rx_en),
        .tick (tick),
        .rxd_s(rxd_s),
        .fmt  (fmt_q),
        .done (frm_done),
        .data (frm_data),
        .info (frm_info)
    );

    mpr_status #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .done      (frm_done),
        .data      (frm_data),
        .info      (frm_info),
        .fmt       (fmt_q),
        .filt_wr   (filt_wr),
        .filt_wdata(filt_wdata),
        .clr       (clr_flags),
        .rdata     (rdata),
        .full      (full),
        .fer       (fer),
        .per       (per),
        .ovr       (ovr),
        .mpb       (mpb),
        .filt_en   (filt_en),
        .accept    (accept)
    );

    assign rx_irq  = rie & full;
    assign err_irq = rie & (fer | per | ovr);
endmodule

// File: rtl/mpr_rx_chk.sv
module mpr_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic              fmt_mp,
    input logic              filt_en,
    input logic              filt_wr,
    input logic              accept,
    input logic [3:0]        clr_flags,
    input logic [DATA_W-1:0] rdata,
    input logic              full,
    input logic              fer,
    input logic              ovr,
    input logic              mpb
);
    // R5: an overrun never disturbs the held data
    a_r5_ovr_keeps_data: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $stable(rdata));

    // R6: a disabled receiver raises no flag
    a_r6_no_flag_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_en) |-> !$rose(full) && !$rose(fer) && !$rose(ovr));

    // R8: while the filter stays armed in multiprocessor mode, nothing lands
    a_r8_filter_blocks: assert property (@(posedge clk) disable iff (rst)
        ($past(filt_en) && $past(fmt_mp) && filt_en) |->
        !$rose(full) && !$rose(fer) && !$rose(ovr));

    // R9: the filter only disarms itself on an address frame
    a_r9_wake_sets_mpb: assert property (@(posedge clk) disable iff (rst)
        ($fell(filt_en) && !$past(filt_wr)) |-> mpb);

    // R11: a load in the same cycle as a clear leaves full set
    a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (accept && !full && clr_flags[0]) |=> full);
endmodule

bind mp_uart_rx mpr_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .fmt_mp   (fmt_q.mp_mode),
    .filt_en  (filt_en),
    .filt_wr  (filt_wr),
    .accept   (accept),
    .clr_flags(clr_flags),
    .rdata    (rdata),
    .full     (full),
    .fer      (fer),
    .ovr      (ovr),
    .mpb      (mpb)
);

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
    localparam int BITC = 32;  // tick every 2 clocks, 16 ticks per bit

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic rxd = 1'b1;
    logic rx_en = 1'b0;
    logic cfg_mp = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic filt_wr = 1'b0, filt_wdata = 1'b0;
    logic rie = 1'b0;
    logic [3:0] clr_flags = 4'h0;
    logic [7:0] rdata;
    logic full, fer, per, ovr, mpb, filt_en, rx_irq, err_irq;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk) tick = ~tick;
    end

    mp_uart_rx u0 (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_en(rx_en),
        .cfg_mp(cfg_mp), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .filt_wr(filt_wr), .filt_wdata(filt_wdata), .rie(rie),
        .clr_flags(clr_flags), .rdata(rdata), .full(full), .fer(fer),
        .per(per), .ovr(ovr), .mpb(mpb), .filt_en(filt_en),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    typedef struct packed {
        logic       mp;
        logic       pe;
        logic       po;
        logic       filt;
        logic [7:0] d;
        logic       xb;
        logic       stop;
        logic       e_full;
        logic       e_fer;
        logic       e_per;
        logic       e_filt;
        logic       e_mpb;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,8'hA5,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R2 plain
        '{1'b0,1'b1,1'b0,1'b0,8'hA5,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 even ok
        '{1'b0,1'b1,1'b0,1'b0,8'hA5,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0}, // R3 even bad
        '{1'b0,1'b1,1'b1,1'b0,8'h3C,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 odd ok
        '{1'b0,1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0}, // R4 bad stop
        '{1'b1,1'b0,1'b0,1'b0,8'h12,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R13 data frame
        '{1'b1,1'b0,1'b0,1'b1,8'h34,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0}, // R8 dropped
        '{1'b1,1'b0,1'b0,1'b1,8'h56,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0}, // R8 no error check
        '{1'b1,1'b0,1'b0,1'b1,8'h78,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1}, // R9 wake
        '{1'b1,1'b0,1'b0,1'b0,8'h9A,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0}, // R13 back to 0
        '{1'b0,1'b0,1'b0,1'b1,8'hBC,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1,1'b0}, // R10 filter idle
        '{1'b1,1'b1,1'b0,1'b0,8'h01,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1}  // R3 no parity in mp
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic has_x, input logic xb, input logic stop);
        rxd = 1'b0; wait_clk(BITC);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; wait_clk(BITC);
        end
        if (has_x) begin
            rxd = xb; wait_clk(BITC);
        end
        rxd = stop; wait_clk(BITC);
        rxd = 1'b1; wait_clk(2 * BITC);
    endtask

    task automatic pulse_clr(input logic [3:0] m);
        clr_flags = m; wait_clk(1); clr_flags = 4'h0; wait_clk(1);
    endtask

    task automatic setup(input logic mp, input logic pe, input logic po, input logic fl);
        rx_en = 1'b0; wait_clk(2);
        cfg_mp = mp; cfg_par_en = pe; cfg_par_odd = po;
        filt_wr = 1'b1; filt_wdata = fl; wait_clk(1); filt_wr = 1'b0;
        pulse_clr(4'hF);
        rx_en = 1'b1; wait_clk(2 * BITC);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait_clk(4); rst = 1'b0; wait_clk(2);
        check("R2 reset full", full, 0);
        check("R4 reset fer", fer, 0);
        check("R5 reset ovr", ovr, 0);
        check("R9 reset filt_en", filt_en, 0);
        check("R12 reset irqs", {rx_irq, err_irq}, 0);

        for (int v = 0; v < NV; v++) begin
            setup(VECS[v].mp, VECS[v].pe, VECS[v].po, VECS[v].filt);
            send(VECS[v].d, VECS[v].mp | VECS[v].pe, VECS[v].xb, VECS[v].stop);
            check($sformatf("R2/R8 vec%0d full", v), full, VECS[v].e_full);
            if (VECS[v].e_full) check($sformatf("R2 vec%0d rdata", v), rdata, VECS[v].d);
            check($sformatf("R4 vec%0d fer", v), fer, VECS[v].e_fer);
            check($sformatf("R3 vec%0d per", v), per, VECS[v].e_per);
            check($sformatf("R9/R10 vec%0d filt_en", v), filt_en, VECS[v].e_filt);
            check($sformatf("R13 vec%0d mpb", v), mpb, VECS[v].e_mpb);
        end

        // R5 overrun and R12 interrupts
        setup(1'b0, 1'b0, 1'b0, 1'b0);
        rie = 1'b1;
        send(8'h11, 1'b0, 1'b0, 1'b1);
        check("R12 rx_irq", rx_irq, 1);
        check("R12 err_irq quiet", err_irq, 0);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        check("R5 ovr set", ovr, 1);
        check("R5 rdata kept", rdata, 8'h11);
        check("R12 err_irq", err_irq, 1);

        // R6 disable keeps flags, no reception while off
        rx_en = 1'b0; wait_clk(4);
        check("R6 flags kept", {full, ovr}, 2'b11);
        pulse_clr(4'hF);
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        check("R6 no rx when off", full, 0);

        // R11 selective clear
        setup(1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h33, 1'b0, 1'b0, 1'b1);
        send(8'h44, 1'b0, 1'b0, 1'b1);
        pulse_clr(4'h1);
        check("R11 full cleared", full, 0);
        check("R11 ovr untouched", ovr, 1);
        pulse_clr(4'h8);
        check("R11 ovr cleared", ovr, 0);
        rie = 1'b0;

        // R7 format change while enabled ignored
        setup(1'b0, 1'b0, 1'b0, 1'b0);
        cfg_par_en = 1'b1;
        send(8'h55, 1'b0, 1'b0, 1'b1);
        check("R7 rdata", rdata, 8'h55);
        check("R7 per", per, 0);
        cfg_par_en = 1'b0;

        // R1 short start glitch rejected
        setup(1'b0, 1'b0, 1'b0, 1'b0);
        rxd = 1'b0; wait_clk(8); rxd = 1'b1; wait_clk(3 * BITC);
        check("R1 glitch ignored", full, 0);
        send(8'hC3, 1'b0, 1'b0, 1'b1);
        check("R1 frame after glitch", rdata, 8'hC3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule